// File: doc/BRIEF.md
# Colour Table Loader

This block holds a 256-entry colour lookup table, each entry being three 8-bit components (red, green, blue), and runs the sequence that loads it from a 32-bit bus. Software first writes an entry number to the index register, then writes the data register once per component. Every value is taken from the most significant byte of the bus word. Components are stored in a fixed order: red, green, blue. After the blue write, the entry number moves on by one on its own, so a run of consecutive entries loads with one index write followed by a stream of data writes.

A display pipeline reads the table through a separate port. It presents an 8-bit pixel value and receives the 24-bit colour one clock later. Each stored component also raises a one-cycle change pulse that carries the entry number, so that downstream logic can mark its cached picture as stale. Reads of the register window always return zero.

Top module: `clut_loader`

## Requirements
- R1: A write at byte offset 0x0 loads the entry index from `bus_wdata[31:24]` and sets the component phase back to red.
- R2: Writes at byte offset 0x4 store `bus_wdata[31:24]` into the red, then the green, then the blue component of the entry the index selects. Phase encoding: 0 means red, 1 means green, 2 means blue.
- R3: The write that stores blue also advances the index by one, modulo 256 (255 wraps to 0), and sets the phase back to red.
- R4: Writes at any offset other than 0x0 and 0x4 (1, 2, 3, 5 to 0xF) change neither the table, the index nor the phase, and raise no change pulse.
- R5: `bus_rdata` is zero in every cycle.
- R6: After reset, every entry reads 0x000000 except entry 255, which reads 0xFFFFFF. The index and the phase are both 0.
- R7: `pix_rgb` shows, one cycle after `pix_idx` is sampled, the colour of that entry packed as red in [23:16], green in [15:8] and blue in [7:0]. If the same edge also writes that entry, the output shows the value from before the write.
- R8: Each write stored by R2 raises `chg_valid` for exactly the next cycle, with `chg_entry` equal to the entry that was written. Index writes raise no pulse.
- R9: An index write in the middle of a triplet keeps the components already stored. The following data write goes to red of the newly selected entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| bus_wr_en | input | 1 | Bus write strobe, one write per cycle |
| bus_addr | input | 4 | Byte offset within the 16-byte register window |
| bus_wdata | input | 32 | Bus write data; only bits 31:24 are used |
| bus_rdata | output | 32 | Bus read data, always zero |
| pix_idx | input | 8 | Pixel value to look up |
| pix_rgb | output | 24 | Registered colour of entry `pix_idx` |
| chg_valid | output | 1 | One-cycle pulse after a component has been stored |
| chg_entry | output | 8 | Entry that the pulsing write changed |

## Verification
The embedded assertions check the sequencer and the storage on every cycle. They confirm that an index write loads the top byte and resets the phase, that red steps to green, that a blue write advances the index with wraparound, that stray offsets leave index and phase untouched, that a bank write lands at its address, and that index writes never pulse the change output. Several behaviours are visible only through the bench's scenarios against its reference model. These are the reset contents of the whole table, the exact R-G-B packing at the read port, the old-value result when a read and a write hit the same entry on the same edge, and the effect of an abandoned partial triplet.

// File: rtl/clut_pkg.sv
package clut_pkg;

  // byte offsets inside the register window; software depends on these
  localparam int unsigned OFS_INDEX = 0;
  localparam int unsigned OFS_DATA  = 4;

  // component phase, order is the load order
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  localparam int unsigned NUM_COMP = 3;

endpackage

// File: rtl/clut_rst_sync.sv
module clut_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [IDX_W-1:0]    wr_top,
  output logic [IDX_W-1:0]    cur_idx,
  output logic [NUM_COMP-1:0] comp_we
);

  localparam logic [ADDR_W-1:0] A_INDEX = ADDR_W'(OFS_INDEX);
  localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(OFS_DATA);

  logic [IDX_W-1:0] idx_q, idx_d;
  phase_e           ph_q, ph_d;
  logic             hit_index, hit_data;
  logic             seq_en;

  assign hit_index = wr_en && (addr == A_INDEX);
  assign hit_data  = wr_en && (addr == A_DATA);
  assign seq_en    = hit_index || hit_data;

  always_comb begin
    idx_d   = idx_q;
    ph_d    = ph_q;
    comp_we = '0;
    if (hit_index) begin
      idx_d = wr_top;
      ph_d  = PH_RED;
    end else if (hit_data) begin
      case (ph_q)
        PH_RED: begin
          comp_we[0] = 1'b1;
          ph_d       = PH_GRN;
        end
        PH_GRN: begin
          comp_we[1] = 1'b1;
          ph_d       = PH_BLU;
        end
        PH_BLU: begin
          comp_we[2] = 1'b1;
          idx_d      = idx_q + 1'b1;
          ph_d       = PH_RED;
        end
        default: begin
          // undefined code: drop the write and resynchronise on red
          ph_d = PH_RED;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      ph_q  <= PH_RED;
    end else if (seq_en) begin
      idx_q <= idx_d;
      ph_q  <= ph_d;
    end
  end

  assign cur_idx = idx_q;

  // R1: index write takes the top byte and restarts at red
  a_r1_index_load: assert property (@(posedge clk) disable iff (!rst_n)
    hit_index |=> (idx_q == $past(wr_top)) && (ph_q == PH_RED));

  // R2: red is followed by green
  a_r2_red_then_green: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_data && ph_q == PH_RED) |=> (ph_q == PH_GRN) && $stable(idx_q));

  // R3: blue advances the index with wraparound
  a_r3_blue_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_data && ph_q == PH_BLU) |=>
      (idx_q == IDX_W'($past(idx_q) + 1'b1)) && (ph_q == PH_RED));

  // R4: stray offsets leave the sequencer alone
  a_r4_stray_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit_index && !hit_data) |=> $stable(idx_q) && $stable(ph_q));

  // R2: at most one component stored per write
  a_r2_single_comp: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(comp_we));

endmodule

// File: rtl/clut_bank.sv
module clut_bank #(
  parameter int unsigned DEPTH   = 256,
  parameter int unsigned DW      = 8,
  parameter logic [DW-1:0] TOP_VAL = '1,
  localparam int unsigned AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rd_q, rd_d;

  // the last entry comes out of reset with TOP_VAL, all others with zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) begin
        mem_q[e] <= (e == DEPTH - 1) ? TOP_VAL : '0;
      end
    end else if (we) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  always_comb begin
    rd_d = mem_q[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;

  // R2: a write lands at its own address
  a_r2_bank_store: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem_q[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/clut_loader.sv
module clut_loader
  import clut_pkg::*;
#(
  parameter int unsigned ENTRIES = 256,
  parameter int unsigned COMP_W  = 8,
  parameter int unsigned BUS_W   = 32,
  parameter int unsigned ADDR_W  = 4,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned RGB_W  = NUM_COMP * COMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic [RGB_W-1:0]  pix_rgb,
  output logic              chg_valid,
  output logic [IDX_W-1:0]  chg_entry
);

  logic                rst_i_n;
  logic [IDX_W-1:0]    cur_idx;
  logic [NUM_COMP-1:0] comp_we;
  logic [COMP_W-1:0]   comp_val;
  logic [IDX_W-1:0]    idx_val;
  logic                chg_valid_q, chg_valid_d;
  logic [IDX_W-1:0]    chg_entry_q, chg_entry_d;

  assign comp_val  = bus_wdata[BUS_W-1 -: COMP_W];
  assign idx_val   = bus_wdata[BUS_W-1 -: IDX_W];
  assign bus_rdata = '0;

  clut_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  clut_seq #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .wr_en   (bus_wr_en),
    .addr    (bus_addr),
    .wr_top  (idx_val),
    .cur_idx (cur_idx),
    .comp_we (comp_we)
  );

  // one bank per component; red sits in the top field of pix_rgb
  for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
    clut_bank #(
      .DEPTH   (ENTRIES),
      .DW      (COMP_W),
      .TOP_VAL ({COMP_W{1'b1}})
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .we      (comp_we[c]),
      .wr_addr (cur_idx),
      .wr_data (comp_val),
      .rd_addr (pix_idx),
      .rd_data (pix_rgb[RGB_W-1-c*COMP_W -: COMP_W])
    );
  end

  always_comb begin
    chg_valid_d = |comp_we;
    chg_entry_d = chg_valid_d ? cur_idx : chg_entry_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      chg_valid_q <= 1'b0;
      chg_entry_q <= '0;
    end else begin
      chg_valid_q <= chg_valid_d;
      chg_entry_q <= chg_entry_d;
    end
  end

  assign chg_valid = chg_valid_q;
  assign chg_entry = chg_entry_q;

  // R8: index writes never produce a change pulse
  a_r8_no_pulse_on_index: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_wr_en && bus_addr == ADDR_W'(OFS_INDEX)) |=> !chg_valid);

  // R4: stray offsets produce no change pulse
  a_r4_no_pulse_on_stray: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_wr_en && bus_addr != ADDR_W'(OFS_INDEX) && bus_addr != ADDR_W'(OFS_DATA))
      |=> !chg_valid);

endmodule

// File: tb/sim_clut_loader.sv
module sim_clut_loader;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pix_idx = '0;
  logic [23:0] pix_rgb;
  logic        chg_valid;
  logic [7:0]  chg_entry;

  always #10 clk = ~clk;

  clut_loader u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pix_idx(pix_idx),
    .pix_rgb(pix_rgb), .chg_valid(chg_valid), .chg_entry(chg_entry)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model state
  logic [7:0]  mr [256];
  logic [7:0]  mg [256];
  logic [7:0]  mb [256];
  logic [7:0]  m_idx = '0;
  int          m_ph = 0;
  bit          model_on = 0;
  bit          exp_ok = 0;
  logic [23:0] exp_pix = '0;
  bit          exp_chg = 0;
  logic [7:0]  exp_ent = '0;

  initial begin
    for (int i = 0; i < 256; i++) begin
      mr[i] = (i == 255) ? 8'hFF : 8'h00;
      mg[i] = (i == 255) ? 8'hFF : 8'h00;
      mb[i] = (i == 255) ? 8'hFF : 8'h00;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model steps on every rising edge, from inputs driven at the falling edge
  always @(posedge clk) begin
    if (model_on) begin
      exp_pix = {mr[pix_idx], mg[pix_idx], mb[pix_idx]};
      exp_chg = 0;
      if (bus_wr_en && bus_addr == 4'h0) begin
        m_idx = bus_wdata[31:24];
        m_ph  = 0;
      end else if (bus_wr_en && bus_addr == 4'h4) begin
        exp_chg = 1;
        exp_ent = m_idx;
        if (m_ph == 0) begin
          mr[m_idx] = bus_wdata[31:24]; m_ph = 1;
        end else if (m_ph == 1) begin
          mg[m_idx] = bus_wdata[31:24]; m_ph = 2;
        end else begin
          mb[m_idx] = bus_wdata[31:24]; m_ph = 0; m_idx = m_idx + 8'd1;
        end
      end
      exp_ok = 1;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (exp_ok && !done) begin
      check(pix_rgb == exp_pix, "R7 pixel port", {8'h0, pix_rgb}, {8'h0, exp_pix});
      check(chg_valid == exp_chg, "R8 change pulse", {31'h0, chg_valid}, {31'h0, exp_chg});
      if (exp_chg)
        check(chg_entry == exp_ent, "R8 change entry", {24'h0, chg_entry}, {24'h0, exp_ent});
      check(bus_rdata == 32'h0, "R5 read data", bus_rdata, 32'h0);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] top);
    bus_wr_en = 1'b1;
    bus_addr  = a;
    bus_wdata = {top, 24'hA5A5A5};
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic peek(input logic [7:0] e, input logic [23:0] exp, input string tag);
    pix_idx = e;
    @(negedge clk);
    check(pix_rgb == exp, tag, {8'h0, pix_rgb}, {8'h0, exp});
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_on = 1;
    @(negedge clk);

    // R6: reset contents
    peek(8'd0,   24'h000000, "R6 entry 0");
    peek(8'd128, 24'h000000, "R6 entry 128");
    peek(8'd255, 24'hFFFFFF, "R6 entry 255");
    check(chg_valid == 1'b0, "R6 no pulse", {31'h0, chg_valid}, 32'h0);

    // R6: index 0 and phase red after reset
    wr(4'h4, 8'h0A); wr(4'h4, 8'h0B); wr(4'h4, 8'h0C);
    peek(8'd0, 24'h0A0B0C, "R6 default index and phase");

    // R1, R2: load one entry
    wr(4'h0, 8'h10);
    wr(4'h4, 8'hAA);
    check(chg_valid && chg_entry == 8'h10, "R8 pulse after red", {24'h0, chg_entry}, 32'h10);
    wr(4'h4, 8'hBB); wr(4'h4, 8'hCC);
    peek(8'h10, 24'hAABBCC, "R1 R2 entry 0x10");

    // R3: auto increment to next entry
    wr(4'h4, 8'h11); wr(4'h4, 8'h22); wr(4'h4, 8'h33);
    peek(8'h11, 24'h112233, "R3 increment");

    // R3: wraparound 255 -> 0
    wr(4'h0, 8'hFF);
    wr(4'h4, 8'h01); wr(4'h4, 8'h02); wr(4'h4, 8'h03);
    wr(4'h4, 8'h04); wr(4'h4, 8'h05); wr(4'h4, 8'h06);
    peek(8'hFF, 24'h010203, "R3 entry 255");
    peek(8'h00, 24'h040506, "R3 wrap to 0");

    // R9: abandoned partial triplet
    wr(4'h0, 8'h30);
    wr(4'h4, 8'h77);
    wr(4'h0, 8'h31);
    wr(4'h4, 8'h12); wr(4'h4, 8'h34); wr(4'h4, 8'h56);
    peek(8'h30, 24'h770000, "R9 partial kept");
    peek(8'h31, 24'h123456, "R9 restart at red");

    // R4: stray offsets ignored
    wr(4'h0, 8'h40);
    wr(4'h8, 8'h99); wr(4'hC, 8'h99); wr(4'h1, 8'h99); wr(4'h5, 8'h99);
    wr(4'h2, 8'h50); wr(4'hF, 8'h99);
    check(chg_valid == 1'b0, "R4 no pulse", {31'h0, chg_valid}, 32'h0);
    wr(4'h4, 8'hDE); wr(4'h4, 8'hAD); wr(4'h4, 8'hBE);
    peek(8'h40, 24'hDEADBE, "R4 index and phase unchanged");
    peek(8'h50, 24'h000000, "R4 stray index ignored");

    // R7: read and write of the same entry on one edge
    wr(4'h0, 8'h60);
    wr(4'h4, 8'h01); wr(4'h4, 8'h02);
    pix_idx   = 8'h60;
    bus_wr_en = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h03000000;
    @(negedge clk);
    bus_wr_en = 1'b0;
    check(pix_rgb == 24'h010200, "R7 old value on collision", {8'h0, pix_rgb}, 32'h010200);
    @(negedge clk);
    check(pix_rgb == 24'h010203, "R7 new value next cycle", {8'h0, pix_rgb}, 32'h010203);

    // R2: a sweep of entries loaded back to back
    wr(4'h0, 8'h80);
    for (int k = 0; k < 8; k++) begin
      wr(4'h4, 8'(k)); wr(4'h4, 8'(k + 16)); wr(4'h4, 8'(k + 32));
    end
    for (int k = 0; k < 8; k++) begin
      peek(8'(8'h80 + k), {8'(k), 8'(k + 16), 8'(k + 32)}, "R2 sweep");
    end

    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule